// File: doc/BRIEF.md
# Bearer Keystream Framer

This block sits between a keystream word generator and a byte-serial data path, and handles the confidentiality side of a bearer. A start pulse loads a 128-bit key given as sixteen bytes, a 32-bit frame count, a bearer identity, a direction flag and a message length in bits. From these the block forms four key words and four initialization words for the generator. It also tells the generator how many 32-bit keystream words the message needs.

Keystream words then arrive on a valid/ready port. Each word is split into four bytes, most significant byte first, and each byte is XORed with one incoming data byte. The results leave on a valid/ready stream, and the final byte carries a last flag. When the bit length is not a whole number of bytes, the unused low-order bits of the final byte are forced to zero. The block takes in exactly as many data bytes as the length covers and no more.

Top module: `bearer_ks_framer`

## Requirements
- R1: After reset, `busy`, `gen_start`, `ks_ready`, `din_ready` and `dout_valid` are all low.
- R2: In `key_in`, byte 0 sits in bits [127:120] and byte 15 in bits [7:0]. The key word built from bytes 4i..4i+3 (first byte most significant) is key word 3-i. `gen_key` holds key word 3 in bits [127:96] down to key word 0 in bits [31:0].
- R3: `gen_iv` holds iv3 in bits [127:96] down to iv0 in bits [31:0], with iv3 = iv1 = count and iv2 = iv0 = bearer[4:0] in bits 31..27 and dir[0] in bit 26, all other bits zero. The upper bearer bits and dir[1] have no effect.
- R4: A start accepted while idle gives a single-cycle `gen_start` pulse in the next cycle, with `gen_words` = ceil(length/32). A start while `busy` is high is ignored.
- R5: Output byte j equals data byte j XOR byte (j mod 4) of keystream word j/4, where byte 0 is bits [31:24].
- R6: When length mod 8 = m is nonzero, the low 8-m bits of the final output byte are zero.
- R7: Exactly ceil(length/8) data bytes are consumed and emitted. `dout_last` is high only with the final byte.
- R8: Exactly ceil(length/32) keystream words are accepted, and `ks_ready` is low while a word is still being used.
- R9: While `dout_valid` is high and `dout_ready` is low, `dout_data` and `dout_last` hold their values.
- R10: A length of zero pulses `gen_start` with zero words, emits no bytes, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load parameters and begin a message |
| key_in | input | 128 | Key bytes, byte 0 in the top bits |
| count_in | input | 32 | Frame count |
| bearer_in | input | 8 | Bearer identity, low 5 bits used |
| dir_in | input | 2 | Direction, bit 0 used |
| len_in | input | LEN_W | Message length in bits |
| busy | output | 1 | Message in progress or output pending |
| gen_start | output | 1 | Generator initialization pulse |
| gen_key | output | 128 | Key words 3..0 |
| gen_iv | output | 128 | Initialization words 3..0 |
| gen_words | output | LEN_W-4 | Keystream words required |
| ks_valid | input | 1 | Keystream word valid |
| ks_ready | output | 1 | Keystream word accepted |
| ks_data | input | 32 | Keystream word |
| din_valid | input | 1 | Data byte valid |
| din_ready | output | 1 | Data byte accepted |
| din_data | input | 8 | Data byte |
| dout_valid | output | 1 | Output byte valid |
| dout_ready | input | 1 | Output byte accepted |
| dout_data | output | 8 | Output byte |
| dout_last | output | 1 | Final byte of the message |

## Verification
The bench builds the block with LEN_W = 8. That brings every bit length from 0 to 255 within a single sweep. The sweep therefore covers all eight trailing-bit residues, every count of keystream words up to eight, and word boundaries falling at every byte position of the last word. The sweep runs with uneven valid patterns on the keystream and data inputs and with output backpressure. It also varies key, count, bearer and direction per length, and it tries to restart the block while it is busy.

// File: rtl/bearer_ks_framer.sv
module bearer_ks_framer #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [127:0]     key_in,
  input  logic [31:0]      count_in,
  input  logic [7:0]       bearer_in,
  input  logic [1:0]       dir_in,
  input  logic [LEN_W-1:0] len_in,
  output logic             busy,
  output logic             gen_start,
  output logic [127:0]     gen_key,
  output logic [127:0]     gen_iv,
  output logic [LEN_W-5:0] gen_words,
  input  logic             ks_valid,
  output logic             ks_ready,
  input  logic [31:0]      ks_data,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_data,
  output logic             dout_last
);
  localparam int WCNT_W = LEN_W - 4;
  localparam int BCNT_W = LEN_W - 2;

  logic              run, ks_have;
  logic [2:0]        len_lo;
  logic [1:0]        bsel;
  logic [31:0]       ks_word;
  logic [BCNT_W-1:0] bytes_left;

  logic [LEN_W:0]    len_ext;
  logic [BCNT_W-1:0] nbytes;
  logic [WCNT_W-1:0] nwords;
  logic [31:0]       iv_mix;
  logic              start_ok, take, last_b, out_free;
  logic [7:0]        ks_byte, mask;

  assign len_ext  = {1'b0, len_in};
  assign nbytes   = BCNT_W'((len_ext + 7) >> 3);
  assign nwords   = WCNT_W'((len_ext + 31) >> 5);
  assign iv_mix   = {bearer_in[4:0], dir_in[0], 26'd0};

  assign busy     = run | dout_valid | gen_start;
  assign start_ok = start & ~busy;
  assign out_free = ~dout_valid | dout_ready;
  assign ks_ready = run & ~ks_have;
  assign din_ready = run & ks_have & out_free;
  assign take     = din_valid & din_ready;
  assign last_b   = bytes_left == BCNT_W'(1);
  assign ks_byte  = ks_word[{~bsel, 3'b111} -: 8];
  assign mask     = (last_b && len_lo != 3'd0) ? ~(8'hFF >> len_lo) : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_start  <= 1'b0;
      gen_key    <= '0;
      gen_iv     <= '0;
      gen_words  <= '0;
      run        <= 1'b0;
      len_lo     <= '0;
      bytes_left <= '0;
    end else begin
      gen_start <= start_ok;
      if (start_ok) begin
        gen_key    <= {key_in[127:96], key_in[95:64], key_in[63:32], key_in[31:0]};
        gen_iv     <= {count_in, iv_mix, count_in, iv_mix};
        gen_words  <= nwords;
        run        <= nbytes != '0;
        len_lo     <= len_in[2:0];
        bytes_left <= nbytes;
      end else if (take) begin
        bytes_left <= bytes_left - 1'b1;
        if (last_b) run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_have <= 1'b0;
      ks_word <= '0;
      bsel    <= '0;
    end else if (start_ok) begin
      ks_have <= 1'b0;
      bsel    <= '0;
    end else if (ks_valid && ks_ready) begin
      ks_word <= ks_data;
      ks_have <= 1'b1;
      bsel    <= '0;
    end else if (take) begin
      bsel <= bsel + 1'b1;
      if (bsel == 2'd3 || last_b) ks_have <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      dout_data  <= '0;
      dout_last  <= 1'b0;
    end else if (take) begin
      dout_valid <= 1'b1;
      dout_data  <= (din_data ^ ks_byte) & mask;
      dout_last  <= last_b;
    end else if (dout_ready) begin
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/bearer_ks_framer_chk.sv
module bearer_ks_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       gen_start,
  input logic       ks_ready,
  input logic       din_ready,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic [7:0] dout_data,
  input logic       dout_last,
  input logic [2:0] len_lo
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dout_valid && !ks_ready && !din_ready));
  // R4
  gen_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_start |=> !gen_start);
  // R6
  tail_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && dout_last && len_lo != 3'd0) |-> ((dout_data & (8'hFF >> len_lo)) == 8'h00));
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_last |-> dout_valid);
  // R8
  word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> !ks_ready);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data) && $stable(dout_last)));
endmodule

bind bearer_ks_framer bearer_ks_framer_chk u_chk (.*);

// File: tb/bearer_ks_framer_bench.sv
module bearer_ks_framer_bench;
  localparam int LEN_W = 8;
  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [127:0] key_in = '0;
  logic [31:0] count_in = '0;
  logic [7:0] bearer_in = '0;
  logic [1:0] dir_in = '0;
  logic [LEN_W-1:0] len_in = '0;
  logic busy, gen_start, ks_ready, din_ready, dout_valid, dout_last;
  logic [127:0] gen_key, gen_iv;
  logic [LEN_W-5:0] gen_words;
  logic ks_valid = 0, din_valid = 0, dout_ready = 0;
  logic [31:0] ks_data = '0;
  logic [7:0] din_data = '0, dout_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bearer_ks_framer #(.LEN_W(LEN_W)) u_bearer_ks_framer (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ksw(int len, int w);
    return 32'h9E3779B9 * (len + 1) ^ (32'h01234567 + w * 32'h10204081);
  endfunction
  function automatic logic [7:0] dbyte(int len, int j);
    return 8'(j * 29 + len * 3 + 5);
  endfunction
  function automatic logic [7:0] kbyte(int len, int b);
    return 8'(b * 17 + len * 11 + 3);
  endfunction

  task automatic run_one(input int len);
    int nbytes = (len + 7) / 8;
    int nwords = (len + 31) / 32;
    int dsent = 0, ksent = 0, orecv = 0, cyc = 0, hold_flag = 0;
    logic [7:0] hold_d;
    logic hold_l;
    logic [31:0] iv2;
    logic [7:0] exp_b;
    bit fire_d, fire_k, fire_o, tried_restart;
    @(negedge clk);
    for (int b = 0; b < 16; b++) key_in[127 - 8*b -: 8] = kbyte(len, b);
    count_in  = 32'hC0DE0000 + len * 32'h00010F01;
    bearer_in = 8'(len * 7 + 8'hA0);
    dir_in    = 2'(len);
    len_in    = LEN_W'(len);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(gen_start == 1'b1, "R4 gen_start", gen_start, 1);
    chk(gen_words == (LEN_W-4)'(nwords), "R4 gen_words", gen_words, nwords);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w = {kbyte(len, 4*i), kbyte(len, 4*i+1), kbyte(len, 4*i+2), kbyte(len, 4*i+3)};
      chk(gen_key[32*(3-i) + 31 -: 32] == w, "R2 key word", gen_key[32*(3-i) + 31 -: 32], w);
    end
    iv2 = ({27'd0, bearer_in[4:0]} << 27) | ({31'd0, dir_in[0]} << 26);
    chk(gen_iv == {count_in, iv2, count_in, iv2}, "R3 iv", gen_iv[63:32], iv2);
    if (len == 0) begin
      @(negedge clk);
      chk(busy == 0 && dout_valid == 0, "R10 zero length idle", busy, 0);
    end
    tried_restart = 0;
    while ((orecv < nbytes || dout_valid) && cyc < 600) begin
      if (hold_flag) begin
        chk(dout_valid && dout_data == hold_d && dout_last == hold_l, "R9 hold", dout_data, hold_d);
      end
      ks_valid   = (cyc % 3) != 1;
      ks_data    = ksw(len, ksent);
      din_valid  = (cyc % 4) != 2;
      din_data   = dbyte(len, dsent);
      dout_ready = ((cyc * 7 + len) % 5) != 0;
      start      = (cyc == 2 && busy && !tried_restart);
      if (start) begin
        tried_restart = 1;
        len_in = LEN_W'(len ^ 8'h55);
      end
      #1;
      fire_d = din_valid && din_ready;
      fire_k = ks_valid && ks_ready;
      fire_o = dout_valid && dout_ready;
      hold_flag = dout_valid && !dout_ready;
      hold_d = dout_data;
      hold_l = dout_last;
      if (fire_o) begin
        exp_b = dbyte(len, orecv) ^ 8'(ksw(len, orecv / 4) >> (24 - 8 * (orecv % 4)));
        if (orecv == nbytes - 1 && len % 8 != 0) exp_b &= ~(8'hFF >> (len % 8));
        chk(dout_data == exp_b, (orecv == nbytes - 1 && len % 8 != 0) ? "R6 tail byte" : "R5 byte",
            dout_data, exp_b);
        chk(dout_last == (orecv == nbytes - 1), "R7 last flag", dout_last, orecv == nbytes - 1);
        orecv++;
      end
      if (fire_d) dsent++;
      if (fire_k) ksent++;
      cyc++;
      @(negedge clk);
      if (tried_restart && cyc == 3) chk(gen_start == 0, "R4 restart ignored", gen_start, 0);
      start = 0;
    end
    din_valid = 1; ks_valid = 1; dout_ready = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!dout_valid && !din_ready && !ks_ready, "R7 nothing beyond length", dout_valid, 0);
    end
    chk(orecv == nbytes, "R7 bytes emitted", orecv, nbytes);
    chk(dsent == nbytes, "R7 bytes consumed", dsent, nbytes);
    chk(ksent == nwords, "R8 words accepted", ksent, nwords);
    chk(cyc < 600, "watchdog", cyc, 600);
    din_valid = 0; ks_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !gen_start && !ks_ready && !din_ready && !dout_valid, "R1 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !ks_ready && !din_ready && !dout_valid, "R1 idle after reset", busy, 0);
    for (int len = 0; len < 256; len++) run_one(len);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule